// File: doc/BRIEF.md
# Cascaded Serial Register Frame Writer

This block is the host-side driver for a string of N identical serial-input devices wired one after another. Each device holds a 12-bit shift register and forwards whatever falls out of its far end to the next device. Every device word is a 4-bit channel address followed by an 8-bit value. On a start request the writer samples, for every device, a valid flag, an address and a value. It packs them into one frame of 12×N bits and sends the frame out on a serial data line with a serial clock. It then raises a load strobe once, so that every device in the string transfers its word at the same moment. Devices whose valid flag is low get an all-zero word. The zero address makes them do nothing when the strobe arrives.

Every minimum pin timing is given as a parameter in nanoseconds, together with the system clock period. The writer turns each one into a whole number of system cycles, rounding up. The controller is a state machine with seven states. ST_IDLE waits for start. ST_SHIFT_LO holds the serial clock low and presents the next data bit. ST_SHIFT_HI holds the serial clock high. ST_LD_GAP is a low gap after the last bit. ST_LD_HIGH drives the load strobe. ST_LD_RECOVER is the quiet time after the strobe. ST_FINISH raises the one-cycle done pulse.

The transitions are these. ST_IDLE goes to ST_SHIFT_LO on start, and the frame is captured at that edge. ST_SHIFT_LO goes to ST_SHIFT_HI when its timer expires. ST_SHIFT_HI goes back to ST_SHIFT_LO when its timer expires and bits remain; otherwise it goes to ST_LD_GAP. ST_LD_GAP goes to ST_LD_HIGH, ST_LD_HIGH goes to ST_LD_RECOVER, and ST_LD_RECOVER goes to ST_FINISH, each when its timer expires. ST_FINISH returns to ST_IDLE after one cycle.

Top module: `dcw_chain_writer`

## Requirements
- R1: While reset is asserted, ser_clk, ser_ld, busy, done and ser_dat are all low.
- R2: One accepted start produces exactly 12×N_DEV rising edges of ser_clk (36 with the default N_DEV=3) before the single rise of ser_ld.
- R3: The word for device k is {addr[4k+3:4k], data[8k+7:8k]}. Device N_DEV-1 is sent first and device 0 last. Within a word the 4 address bits go out MSB first, then the 8 data bits MSB first. A bit is taken as valid at the rising edge of ser_clk.
- R4: A device whose dev_valid bit is 0 receives twelve zero bits (address 0000, value 0x00), whatever its address and value inputs hold.
- R5: Before every rise, ser_clk is low for max(ceil(T_SETUP/P), ceil(T_CLK_LO/P)) cycles, which is 8 by default. After every rise it is high for max(ceil(T_CLK_HI/P), ceil(T_HOLD/P)) cycles, which is 8 by default. ser_dat changes only on a falling ser_clk edge or at the capture edge.
- R6: ser_ld stays low during shifting and is never high together with ser_clk. It rises ceil(T_CLK_TO_LD/P) cycles (4) after the last ser_clk fall and stays high ceil(T_LD/P) cycles (9).
- R7: done rises ceil(T_LD_TO_CLK/P) cycles (8) after ser_ld falls. It lasts exactly one cycle, and busy is low in the cycle after it.
- R8: A start while busy is high is ignored. The frame in progress finishes unchanged and no second frame follows.
- R9: The device inputs are sampled only at the accepted start. Changes to them during a frame do not alter the bits sent.
- R10: Outside a frame, ser_clk and ser_ld idle low. busy is high from the edge that accepts start up to and including the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to send one frame; accepted only when idle |
| dev_valid | input | N_DEV | Per-device flag: word pending for that device |
| dev_addr | input | 4·N_DEV | Channel addresses, device k at bits [4k+3:4k] |
| dev_data | input | 8·N_DEV | Values, device k at bits [8k+7:8k] |
| ser_clk | output | 1 | Serial clock to the chain, idles low |
| ser_dat | output | 1 | Serial data into the first device of the chain |
| ser_ld | output | 1 | Load strobe shared by all devices |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse when a frame is complete |

## Verification
The hardest conditions to reach from the ports are a second start arriving in the middle of a frame, and device inputs that move after the frame has been captured. Either one would only show up as a corrupted or repeated frame. The stimulus lets a frame run for a few hundred cycles and then pulses start with a completely different set of inputs, or simply rewrites the inputs. The scoreboard queue holds only the bits of the frame that was accepted. Any restart or late sampling therefore shows up as a wrong bit, an extra bit or an extra done pulse.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT_LO,
        ST_SHIFT_HI,
        ST_LD_GAP,
        ST_LD_HIGH,
        ST_LD_RECOVER,
        ST_FINISH
    } wr_state_t;

    // Whole system cycles covering a time in ns, never fewer than one.
    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned period_ns);
        int unsigned c;
        c = (ns + period_ns - 1) / period_ns;
        if (c == 0) c = 1;
        return c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dcw_frame_pack.sv
module dcw_frame_pack #(
    parameter int unsigned N_DEV  = 3,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic [N_DEV-1:0]                  dev_valid,
    input  logic [N_DEV*ADDR_W-1:0]           dev_addr,
    input  logic [N_DEV*DATA_W-1:0]           dev_data,
    output logic [N_DEV*(ADDR_W+DATA_W)-1:0]  frame
);
    localparam int unsigned WORD_W = ADDR_W + DATA_W;

    // Device k occupies slice k; the top slice leaves the shifter first
    // and therefore travels to the far end of the chain.
    for (genvar gi = 0; gi < N_DEV; gi++) begin : g_word
        assign frame[gi*WORD_W +: WORD_W] = dev_valid[gi]
            ? {dev_addr[gi*ADDR_W +: ADDR_W], dev_data[gi*DATA_W +: DATA_W]}
            : {WORD_W{1'b0}};
    end

endmodule

// File: rtl/dcw_shift_reg.sv
module dcw_shift_reg #(
    parameter int unsigned W = 36
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift) begin
            q <= {q[W-2:0], 1'b0};
        end
    end

    assign msb = q[W-1];

endmodule

// File: rtl/dcw_phase_timer.sv
module dcw_phase_timer #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/dcw_chain_writer.sv
module dcw_chain_writer #(
    parameter int unsigned N_DEV          = 3,
    parameter int unsigned ADDR_W         = 4,
    parameter int unsigned DATA_W         = 8,
    parameter int unsigned SYS_CLK_NS     = 8,
    parameter int unsigned T_SETUP_NS     = 40,
    parameter int unsigned T_HOLD_NS      = 20,
    parameter int unsigned T_CLK_HI_NS    = 60,
    parameter int unsigned T_CLK_LO_NS    = 60,
    parameter int unsigned T_LD_NS        = 70,
    parameter int unsigned T_CLK_TO_LD_NS = 30,
    parameter int unsigned T_LD_TO_CLK_NS = 60
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [N_DEV-1:0]          dev_valid,
    input  logic [N_DEV*ADDR_W-1:0]   dev_addr,
    input  logic [N_DEV*DATA_W-1:0]   dev_data,
    output logic                      ser_clk,
    output logic                      ser_dat,
    output logic                      ser_ld,
    output logic                      busy,
    output logic                      done
);
    import dcw_pkg::*;

    localparam int unsigned WORD_W  = ADDR_W + DATA_W;
    localparam int unsigned FRAME_W = N_DEV * WORD_W;
    localparam int unsigned BIT_W   = $clog2(FRAME_W + 1);

    localparam int unsigned LO_CYC  = max2(ns_to_cycles(T_SETUP_NS, SYS_CLK_NS),
                                           ns_to_cycles(T_CLK_LO_NS, SYS_CLK_NS));
    localparam int unsigned HI_CYC  = max2(ns_to_cycles(T_CLK_HI_NS, SYS_CLK_NS),
                                           ns_to_cycles(T_HOLD_NS, SYS_CLK_NS));
    localparam int unsigned GAP_CYC = ns_to_cycles(T_CLK_TO_LD_NS, SYS_CLK_NS);
    localparam int unsigned LD_CYC  = ns_to_cycles(T_LD_NS, SYS_CLK_NS);
    localparam int unsigned REC_CYC = ns_to_cycles(T_LD_TO_CLK_NS, SYS_CLK_NS);
    localparam int unsigned MAX_CYC = max2(max2(LO_CYC, HI_CYC),
                                           max2(max2(GAP_CYC, LD_CYC), REC_CYC));
    localparam int unsigned TMR_W   = $clog2(MAX_CYC + 1);

    localparam logic [TMR_W-1:0] LO_LD  = TMR_W'(LO_CYC - 1);
    localparam logic [TMR_W-1:0] HI_LD  = TMR_W'(HI_CYC - 1);
    localparam logic [TMR_W-1:0] GAP_LD = TMR_W'(GAP_CYC - 1);
    localparam logic [TMR_W-1:0] LD_LD  = TMR_W'(LD_CYC - 1);
    localparam logic [TMR_W-1:0] REC_LD = TMR_W'(REC_CYC - 1);
    localparam logic [BIT_W-1:0] FRAME_CNT = BIT_W'(FRAME_W);

    wr_state_t          state_q, state_d;
    logic [BIT_W-1:0]   bits_left_q, bits_left_d;
    logic               tmr_load;
    logic [TMR_W-1:0]   tmr_val;
    logic               tmr_expired;
    logic               frame_load;
    logic               shift_en;
    logic [FRAME_W-1:0] frame_packed;

    dcw_frame_pack #(
        .N_DEV (N_DEV),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_pack (
        .dev_valid(dev_valid),
        .dev_addr (dev_addr),
        .dev_data (dev_data),
        .frame    (frame_packed)
    );

    dcw_shift_reg #(
        .W(FRAME_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (frame_load),
        .load_val(frame_packed),
        .shift   (shift_en),
        .msb     (ser_dat)
    );

    dcw_phase_timer #(
        .CW(TMR_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_expired)
    );

    // Next-state and datapath control
    always_comb begin
        state_d     = state_q;
        bits_left_d = bits_left_q;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        frame_load  = 1'b0;
        shift_en    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d     = ST_SHIFT_LO;
                    frame_load  = 1'b1;
                    bits_left_d = FRAME_CNT;
                    tmr_load    = 1'b1;
                    tmr_val     = LO_LD;
                end
            end
            ST_SHIFT_LO: begin
                if (tmr_expired) begin
                    state_d  = ST_SHIFT_HI;
                    tmr_load = 1'b1;
                    tmr_val  = HI_LD;
                end
            end
            ST_SHIFT_HI: begin
                if (tmr_expired) begin
                    shift_en    = 1'b1;
                    bits_left_d = bits_left_q - 1'b1;
                    tmr_load    = 1'b1;
                    if (bits_left_q == BIT_W'(1)) begin
                        state_d = ST_LD_GAP;
                        tmr_val = GAP_LD;
                    end else begin
                        state_d = ST_SHIFT_LO;
                        tmr_val = LO_LD;
                    end
                end
            end
            ST_LD_GAP: begin
                if (tmr_expired) begin
                    state_d  = ST_LD_HIGH;
                    tmr_load = 1'b1;
                    tmr_val  = LD_LD;
                end
            end
            ST_LD_HIGH: begin
                if (tmr_expired) begin
                    state_d  = ST_LD_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = REC_LD;
                end
            end
            ST_LD_RECOVER: begin
                if (tmr_expired) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            bits_left_q <= '0;
        end else begin
            state_q     <= state_d;
            bits_left_q <= bits_left_d;
        end
    end

    // Registered pin outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_clk <= 1'b0;
            ser_ld  <= 1'b0;
            busy    <= 1'b0;
            done    <= 1'b0;
        end else begin
            ser_clk <= (state_d == ST_SHIFT_HI);
            ser_ld  <= (state_d == ST_LD_HIGH);
            busy    <= (state_d != ST_IDLE);
            done    <= (state_d == ST_FINISH);
        end
    end

endmodule

// File: rtl/dcw_chain_writer_chk.sv
module dcw_chain_writer_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic ser_clk,
    input logic ser_dat,
    input logic ser_ld,
    input logic busy,
    input logic done
);
    // R6
    strobe_apart_from_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ser_ld && ser_clk));

    // R6
    strobe_rise_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_ld) |-> (!ser_clk && !$past(ser_clk)));

    // R5
    data_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> (ser_dat == $past(ser_dat)));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_releases_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R10
    idle_lines_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ser_clk && !ser_ld && !done));

    // R10
    start_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

endmodule

bind dcw_chain_writer dcw_chain_writer_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .ser_clk(ser_clk),
    .ser_dat(ser_dat),
    .ser_ld (ser_ld),
    .busy   (busy),
    .done   (done)
);

// File: tb/tb_dcw_chain_writer.sv
module tb_dcw_chain_writer;
    localparam int N   = 3;
    localparam int AW  = 4;
    localparam int DW  = 8;
    localparam int WW  = AW + DW;
    localparam int FW  = N * WW;
    localparam int PER = 8;

    function automatic int cdiv(input int ns);
        return (ns + PER - 1) / PER;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_LO  = mx(cdiv(40), cdiv(60));
    localparam int E_SU  = cdiv(40);
    localparam int E_HI  = mx(cdiv(60), cdiv(20));
    localparam int E_GAP = cdiv(30);
    localparam int E_LD  = cdiv(70);
    localparam int E_REC = cdiv(60);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [N-1:0]    dv = '0;
    logic [N*AW-1:0] da = '0;
    logic [N*DW-1:0] dd = '0;
    logic ser_clk, ser_dat, ser_ld, busy, done;

    always #4 clk = ~clk;

    dcw_chain_writer dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .dev_valid(dv),
        .dev_addr (da),
        .dev_data (dd),
        .ser_clk  (ser_clk),
        .ser_dat  (ser_dat),
        .ser_ld   (ser_ld),
        .busy     (busy),
        .done     (done)
    );

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit    exp_q[$];
    string tag_q[$];
    int frames_exp = 0;
    int frames_done = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            check(1'b0, "R2", "watchdog expired before frames completed", frames_done, frames_exp);
            summary();
            $finish;
        end
    end

    // Monitor / scoreboard
    logic p_clk = 0, p_dat = 0, p_ld = 0, p_done = 0, p_busy = 0;
    int low_run = 0, high_run = 0, stab_run = 0, ld_run = 0;
    int bits_frame = 0, ld_fall_cyc = 0;
    bit hold_bad = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && !p_busy) bits_frame = 0;
            if (ser_clk && !p_clk) begin
                check(low_run == E_LO, "R5", "low phase before clock rise", low_run, E_LO);
                check(stab_run + 1 >= E_SU, "R5", "data setup cycles", stab_run + 1, E_SU);
                check(!ser_ld, "R6", "strobe low while shifting", ser_ld, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8", "serial bit with no frame queued", 1, 0);
                end else begin
                    bit    eb;
                    string et;
                    eb = exp_q.pop_front();
                    et = tag_q.pop_front();
                    check(ser_dat == eb, et, "serial bit value", ser_dat, eb);
                end
                bits_frame++;
            end
            if (!ser_clk && p_clk) begin
                check(high_run == E_HI, "R5", "high phase length", high_run, E_HI);
                check(!hold_bad, "R5", "data held while clock high", hold_bad, 0);
                hold_bad = 0;
            end
            if (ser_clk && p_clk && ser_dat != p_dat) hold_bad = 1;
            if (ser_ld && !p_ld) begin
                check(bits_frame == FW, "R2", "clock rises before strobe", bits_frame, FW);
                check(low_run == E_GAP, "R6", "last fall to strobe gap", low_run, E_GAP);
            end
            if (!ser_ld && p_ld) begin
                check(ld_run == E_LD, "R6", "strobe width", ld_run, E_LD);
                ld_fall_cyc = cyc;
            end
            if (done && !p_done) begin
                frames_done++;
                check(cyc - ld_fall_cyc == E_REC, "R7", "strobe fall to done",
                      cyc - ld_fall_cyc, E_REC);
                check(busy, "R10", "busy during done", busy, 1);
            end
            if (p_done) begin
                check(!done, "R7", "done width one cycle", done, 0);
                check(!busy, "R7", "busy low after done", busy, 0);
            end
            low_run  = (busy && !ser_clk && !ser_ld) ? low_run + 1 : 0;
            high_run = ser_clk ? high_run + 1 : 0;
            ld_run   = ser_ld ? ld_run + 1 : 0;
            stab_run = (ser_dat == p_dat) ? stab_run + 1 : 0;
        end
        p_clk  = ser_clk;
        p_dat  = ser_dat;
        p_ld   = ser_ld;
        p_done = done;
        p_busy = busy;
    end

    // Driver: requests one frame and queues its expected bits
    task automatic send(input logic [N-1:0] v, input logic [N*AW-1:0] a,
                        input logic [N*DW-1:0] d, input string tg);
        @(negedge clk);
        while (busy) @(negedge clk);
        dv = v;
        da = a;
        dd = d;
        start = 1'b1;
        for (int k = N - 1; k >= 0; k--) begin
            logic [WW-1:0] w;
            w = v[k] ? {a[k*AW +: AW], d[k*DW +: DW]} : '0;
            for (int b = WW - 1; b >= 0; b--) begin
                exp_q.push_back(w[b]);
                tag_q.push_back(v[k] ? tg : "R4");
            end
        end
        frames_exp++;
        @(negedge clk);
        start = 1'b0;
        check(busy, "R10", "busy after start accepted", busy, 1);
    endtask

    task automatic wait_done();
        while (frames_done < frames_exp) @(negedge clk);
        @(negedge clk);
        check(!ser_clk && !ser_ld && !busy, "R10", "lines idle after frame",
              {ser_clk, ser_ld, busy}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!ser_clk, "R1", "ser_clk in reset", ser_clk, 0);
        check(!ser_ld, "R1", "ser_ld in reset", ser_ld, 0);
        check(!busy, "R1", "busy in reset", busy, 0);
        check(!done, "R1", "done in reset", done, 0);
        check(!ser_dat, "R1", "ser_dat in reset", ser_dat, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R3: all devices valid, distinct words
        send(3'b111, {4'h3, 4'h2, 4'h1}, {8'hA5, 8'h3C, 8'h81}, "R3");
        wait_done();

        // R4: only the middle device valid, others carry nonzero junk
        send(3'b010, 12'h5A7, 24'hFFFFFF, "R3");
        wait_done();

        // R4: no device valid, whole frame is zero
        send(3'b000, 12'hFFF, 24'hFFFFFF, "R3");
        wait_done();

        // R3: extreme patterns with one hole
        send(3'b101, 12'hF0F, 24'hFF00FF, "R3");
        wait_done();

        // R8: start pulsed mid-frame with other inputs
        send(3'b111, 12'h123, 24'h0F0F0F, "R8");
        repeat (100) @(negedge clk);
        dv = 3'b111;
        da = 12'hEDC;
        dd = 24'hF0F0F0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy, "R8", "busy kept through ignored start", busy, 1);
        wait_done();
        repeat (40) @(negedge clk);
        check(frames_done == frames_exp, "R8", "done pulses after ignored start",
              frames_done, frames_exp);

        // R9: inputs rewritten during the frame without start
        send(3'b111, 12'h8C1, 24'h7E0180, "R9");
        repeat (200) @(negedge clk);
        dv = 3'b000;
        da = 12'h000;
        dd = 24'hFFFFFF;
        wait_done();

        // Back-to-back frame right after done
        send(3'b011, 12'h0A5, 24'h55AA01, "R3");
        wait_done();

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R2", "expected bits left unsent", exp_q.size(), 0);
        check(frames_done == frames_exp, "R2", "frames completed", frames_done, frames_exp);
        summary();
        $finish;
    end

endmodule